// File: doc/BRIEF.md
# Soft-Decision Symbol Capture and Alignment Front-End

This block sits in front of a Viterbi decoder core. Each time the data-ready strobe falls, it takes in one set of 3-bit soft-decision symbols (G1, G2 and, at rate 1/3, G3) together with two puncture flags. Every symbol becomes a small signed metric. The incoming code can be either signed-magnitude or two's-complement, and a select input picks which. Punctured symbols and, at rate 1/2, the G3 symbol are forced to a zero-weight metric.

The metrics are then placed into G1/G2/G3 slots according to a 2-bit node-sync phase. A copy of the previous symbol set is kept, so a phase that shifts the grouping by one or two symbols can fill its early slots from period n-1. The aligned set is registered and marked by a one-cycle valid pulse. An active-low acknowledge pulse follows the capture after a fixed number of system clocks set by a parameter.

All inputs are synchronous to `clk`. The strobe is sampled like any other input, and a falling edge is detected from its registered copy.

Top module: `soft_symbol_frontend`

## Requirements
- R1: A capture happens at the `clk` edge where `strobe` is seen low after being high in the previous cycle. At that edge the symbol, flag and mode inputs are sampled, and the aligned outputs and `br_valid` are updated. `br_valid` is high for exactly that one cycle. The outputs keep their values until the next capture.
- R2: With `code_sm`=1 (signed-magnitude), bit 2 of a symbol is the sign (1 = negative) and bits 1:0 form the confidence k. The metric is +(2k+1) or -(2k+1), as 4-bit two's complement. So 000→+1, 011→+7, 100→-1 and 111→-7.
- R3: With `code_sm`=0 (two's-complement), a symbol with bit 2 low gives +(2k+1) with k = bits 1:0. A symbol with bit 2 high gives -(2k+1) with k = the inverse of bits 1:0. So 111→-1, 110→-3, 101→-5 and 100→-7.
- R4: A hard-decision symbol (data on bit 2, bits 1:0 tied high, `code_sm`=1) gives +7 for data 0 and -7 for data 1.
- R5: A high `punc_g1` or `punc_g2` at a capture replaces that symbol's metric with 0. The zero is also what is kept as that symbol's previous-period value.
- R6: With `rate_half`=1, the G3 input has no effect. Slot G3 of the output is 0, and the G3 value kept for the next period is 0.
- R7: With `rate_half`=1, `phase` = {first sync bit, second sync bit} selects the slots (G1,G2) as follows. 00 gives (G1n, G2n). 10 gives (G2n-1, G1n). 01 gives (G2n, G1n).
- R8: With `rate_half`=0, `phase` selects the slots (G1,G2,G3) as follows. 00 gives (G1n, G2n, G3n). 10 gives (G3n-1, G1n, G2n). 01 gives (G2n-1, G3n-1, G1n).
- R9: The `phase` code 11 is treated as 00 at both rates.
- R10: The previous-period metrics are updated at every capture. Reset clears them to 0.
- R11: `ack_n` goes low for exactly one cycle, ACK_DLY clock edges after the capture edge. A new capture before then restarts the count, and only the newer capture produces a pulse.
- R12: After reset the three metric outputs are 0, `br_valid` is 0 and `ack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Data-ready strobe; falling edge triggers a capture |
| code_sm | input | 1 | 1 = signed-magnitude input code, 0 = two's-complement |
| rate_half | input | 1 | 1 = rate 1/2 (also used when punctured), 0 = rate 1/3 |
| phase | input | 2 | Node-sync phase {first, second} |
| punc_g1 | input | 1 | G1 symbol punctured |
| punc_g2 | input | 1 | G2 symbol punctured |
| sym_g1 | input | 3 | G1 soft symbol |
| sym_g2 | input | 3 | G2 soft symbol |
| sym_g3 | input | 3 | G3 soft symbol |
| br_g1 | output | 4 | Aligned G1 slot metric (signed) |
| br_g2 | output | 4 | Aligned G2 slot metric (signed) |
| br_g3 | output | 4 | Aligned G3 slot metric (signed) |
| br_valid | output | 1 | One-cycle pulse marking a new aligned set |
| ack_n | output | 1 | Active-low acknowledge pulse |

## Verification
Some rules are checked by the embedded properties on every cycle. The valid pulse lasts one cycle, and the slot outputs do not change between captures. Every nonzero metric is odd. Slot G3 is zero at rate 1/2, a punctured G1 in direct phase gives a zero slot, and the acknowledge low lasts one cycle. Other behaviour needs the bench's scenarios, because it depends on a sequence of captures. This covers the exact code-to-metric values and each phase shifting symbols from the previous period. It also covers the stored zero of a punctured or ignored symbol reappearing one period later, and the acknowledge delay together with its restart.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam int SYM_W = 3;
  localparam int MET_W = SYM_W + 1;
  localparam int NSYM  = 3;

  typedef logic signed [MET_W-1:0] metric_t;

  typedef enum logic [1:0] {
    PH_DIRECT = 2'b00,
    PH_SECOND = 2'b01,
    PH_FIRST  = 2'b10,
    PH_BAD    = 2'b11
  } phase_e;

  // Soft symbol to odd signed metric: magnitude 2k+1, sign from the MSB.
  function automatic metric_t sym_to_metric(input logic [SYM_W-1:0] s,
                                            input logic sm);
    logic [SYM_W-2:0] k;
    logic [MET_W-1:0] mag;
    k = s[SYM_W-2:0];
    if (!sm && s[SYM_W-1]) k = ~k;
    mag = {1'b0, k, 1'b1};
    return s[SYM_W-1] ? metric_t'(-mag) : metric_t'(mag);
  endfunction

endpackage

// File: rtl/sfe_edge.sv
module sfe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall
);
  logic strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign fall = strobe_q & ~strobe;

endmodule

// File: rtl/sfe_convert.sv
module sfe_convert
  import sfe_pkg::*;
(
  input  logic                      code_sm,
  input  logic [NSYM-1:0][SYM_W-1:0] sym,
  input  logic [NSYM-1:0]           kill,
  output metric_t [NSYM-1:0]        met
);
  for (genvar i = 0; i < NSYM; i++) begin : g_sym
    always_comb begin
      if (kill[i]) met[i] = '0;
      else         met[i] = sym_to_metric(sym[i], code_sm);
    end
  end

endmodule

// File: rtl/sfe_align.sv
module sfe_align
  import sfe_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap,
  input  logic               rate_half,
  input  logic [1:0]         phase,
  input  metric_t [NSYM-1:0] cur,
  output metric_t [NSYM-1:0] br,
  output logic               valid
);
  metric_t [NSYM-1:0] prev;
  metric_t [NSYM-1:0] sel;
  phase_e             ph;

  always_comb begin
    ph = phase_e'(phase);
    if (ph == PH_BAD) ph = PH_DIRECT;
    sel = cur;
    if (rate_half) begin
      sel[2] = '0;
      unique case (ph)
        PH_FIRST:  begin sel[0] = prev[1]; sel[1] = cur[0]; end
        PH_SECOND: begin sel[0] = cur[1];  sel[1] = cur[0]; end
        default:   begin sel[0] = cur[0];  sel[1] = cur[1]; end
      endcase
    end else begin
      unique case (ph)
        PH_FIRST:  begin sel[0] = prev[2]; sel[1] = cur[0];  sel[2] = cur[1]; end
        PH_SECOND: begin sel[0] = prev[1]; sel[1] = prev[2]; sel[2] = cur[0]; end
        default:   sel = cur;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= '0;
      br    <= '0;
      valid <= 1'b0;
    end else begin
      valid <= cap;
      if (cap) begin
        prev <= cur;
        br   <= sel;
      end
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(br)) else $error("slots changed without capture"); // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid) else $error("valid longer than one cycle"); // R1

endmodule

// File: rtl/sfe_ack.sv
module sfe_ack #(
  parameter int ACK_DLY = 68
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  output logic ack_n
);
  localparam int CW = $clog2(ACK_DLY + 1);

  logic [CW-1:0] cnt;
  logic          busy;
  logic          fire;

  assign fire = busy && (cnt == '0) && !cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      busy  <= 1'b0;
      ack_n <= 1'b1;
    end else begin
      ack_n <= ~fire;
      if (cap) begin
        cnt  <= CW'(ACK_DLY - 1);
        busy <= 1'b1;
      end else if (fire) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_ACK_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> ack_n) else $error("ack low too long"); // R11
  AST_ACK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cap) |=> ack_n) else $error("ack without pending capture"); // R11

endmodule

// File: rtl/soft_symbol_frontend.sv
module soft_symbol_frontend
  import sfe_pkg::*;
#(
  parameter int ACK_DLY = 68
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             code_sm,
  input  logic             rate_half,
  input  logic [1:0]       phase,
  input  logic             punc_g1,
  input  logic             punc_g2,
  input  logic [SYM_W-1:0] sym_g1,
  input  logic [SYM_W-1:0] sym_g2,
  input  logic [SYM_W-1:0] sym_g3,
  output logic [MET_W-1:0] br_g1,
  output logic [MET_W-1:0] br_g2,
  output logic [MET_W-1:0] br_g3,
  output logic             br_valid,
  output logic             ack_n
);
  logic                      cap_evt;
  logic [NSYM-1:0][SYM_W-1:0] sym_vec;
  logic [NSYM-1:0]           kill_vec;
  metric_t [NSYM-1:0]        cur_met;
  metric_t [NSYM-1:0]        br_vec;

  assign sym_vec  = {sym_g3, sym_g2, sym_g1};
  assign kill_vec = {rate_half, punc_g2, punc_g1};

  sfe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .fall   (cap_evt)
  );

  sfe_convert u_conv (
    .code_sm (code_sm),
    .sym     (sym_vec),
    .kill    (kill_vec),
    .met     (cur_met)
  );

  sfe_align u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap_evt),
    .rate_half (rate_half),
    .phase     (phase),
    .cur       (cur_met),
    .br        (br_vec),
    .valid     (br_valid)
  );

  sfe_ack #(.ACK_DLY(ACK_DLY)) u_ack (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap_evt),
    .ack_n (ack_n)
  );

  assign br_g1 = br_vec[0];
  assign br_g2 = br_vec[1];
  assign br_g3 = br_vec[2];

  AST_HALF_G3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && rate_half) |=> (br_g3 == '0)) else $error("G3 slot not zero"); // R6
  AST_PUNCT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && punc_g1 && phase == 2'b00) |=> (br_g1 == '0)) else $error("punctured G1 not zero"); // R5
  AST_ODD_METRIC: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> ((br_g1 == '0 || br_g1[0]) && (br_g2 == '0 || br_g2[0]) && (br_g3 == '0 || br_g3[0])))
    else $error("even nonzero metric"); // R2
  AST_VALID_AFTER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> br_valid) else $error("capture without valid"); // R1

endmodule

// File: tb/soft_symbol_frontend_tb.sv
module soft_symbol_frontend_tb;

  localparam int ACK_DLY = 8;
  localparam int NV = 12;

  typedef struct packed {
    logic       sm;
    logic       half;
    logic [1:0] ph;
    logic       p1;
    logic       p2;
    logic [2:0] s1;
    logic [2:0] s2;
    logic [2:0] s3;
    logic [3:0] e1;
    logic [3:0] e2;
    logic [3:0] e3;
  } vec_t;

  // Sequence-dependent: previous-period values carry from one row to the next.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 3'b011, 3'b100, 3'b101, 4'h7, 4'hF, 4'h0},
    '{1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 3'b001, 3'b110, 3'b011, 4'hF, 4'h3, 4'h0},
    '{1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 3'b111, 3'b100, 3'b000, 4'h9, 4'hF, 4'h0},
    '{1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 3'b010, 3'b111, 3'b100, 4'h5, 4'h9, 4'hF},
    '{1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 3'b101, 3'b001, 3'b110, 4'hF, 4'hB, 4'h3},
    '{1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 3'b011, 3'b010, 3'b100, 4'h3, 4'hD, 4'h7},
    '{1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 3'b011, 3'b101, 3'b111, 4'h0, 4'hD, 4'h0},
    '{1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 3'b110, 3'b011, 3'b000, 4'hD, 4'hB, 4'h0},
    '{1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 3'b000, 3'b000, 3'b000, 4'h0, 4'h1, 4'h0},
    '{1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 3'b100, 3'b011, 3'b001, 4'hF, 4'h7, 4'h3},
    '{1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 3'b111, 3'b010, 3'b011, 4'h9, 4'h5, 4'h0},
    '{1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 3'b011, 3'b011, 3'b011, 4'h0, 4'h7, 4'h7}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic       code_sm = 1'b1;
  logic       rate_half = 1'b1;
  logic [1:0] phase = 2'b00;
  logic       punc_g1 = 1'b0;
  logic       punc_g2 = 1'b0;
  logic [2:0] sym_g1 = '0, sym_g2 = '0, sym_g3 = '0;
  logic [3:0] br_g1, br_g2, br_g3;
  logic       br_valid, ack_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  soft_symbol_frontend #(.ACK_DLY(ACK_DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .code_sm(code_sm),
    .rate_half(rate_half), .phase(phase), .punc_g1(punc_g1), .punc_g2(punc_g2),
    .sym_g1(sym_g1), .sym_g2(sym_g2), .sym_g3(sym_g3),
    .br_g1(br_g1), .br_g2(br_g2), .br_g3(br_g3),
    .br_valid(br_valid), .ack_n(ack_n)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Raises the strobe, drops it, and returns just after the capture edge.
  task automatic capture(input vec_t v);
    @(negedge clk);
    code_sm = v.sm; rate_half = v.half; phase = v.ph;
    punc_g1 = v.p1; punc_g2 = v.p2;
    sym_g1 = v.s1; sym_g2 = v.s2; sym_g3 = v.s3;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      #1;
      n++;
      if (!ack_n) break;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    int   n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R12 reset state
    check("R12 br_g1 reset", br_g1, 4'h0);
    check("R12 br_g2 reset", br_g2, 4'h0);
    check("R12 br_g3 reset", br_g3, 4'h0);
    check("R12 valid reset", br_valid, 1'b0);
    check("R12 ack_n reset", ack_n, 1'b1);

    // Table: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      capture(VEC[i]);
      check($sformatf("R1 valid vec %0d", i), br_valid, 1'b1);
      check($sformatf("R7_R8 g1 vec %0d", i), br_g1, VEC[i].e1);
      check($sformatf("R7_R8 g2 vec %0d", i), br_g2, VEC[i].e2);
      check($sformatf("R6 g3 vec %0d", i), br_g3, VEC[i].e3);
      @(posedge clk);
      #1;
      check($sformatf("R1 valid drop vec %0d", i), br_valid, 1'b0);
    end

    // R1 hold: inputs change without a capture
    sym_g1 = 3'b100; sym_g2 = 3'b100; phase = 2'b00;
    repeat (4) @(posedge clk);
    #1;
    check("R1 hold g1", br_g1, 4'h0);
    check("R1 hold g2", br_g2, 4'h7);
    check("R1 hold g3", br_g3, 4'h7);

    // R4 hard decision, both polarities
    v = '{1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 3'b011, 3'b111, 3'b011, 4'h7, 4'h9, 4'h7};
    capture(v);
    check("R4 hard data0", br_g1, 4'h7);
    check("R4 hard data1", br_g2, 4'h9);

    // R11 acknowledge delay and width
    wait_ack(n);
    check("R11 ack delay", n, ACK_DLY);
    @(posedge clk);
    #1;
    check("R11 ack width", ack_n, 1'b1);

    // R11 restart by a second capture
    capture(v);
    repeat (2) @(posedge clk);
    capture(v);
    wait_ack(n);
    check("R11 ack restart delay", n, ACK_DLY);

    // R10 R12 reset clears previous-period values
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R12 br_g2 after reset", br_g2, 4'h0);
    v = '{1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 3'b011, 3'b001, 3'b001, 4'h0, 4'h7, 4'h0};
    capture(v);
    check("R10 cleared prev g1", br_g1, v.e1);
    check("R10 current g2", br_g2, v.e2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule